// File: doc/BRIEF.md
# PHY Reset and Low-Power Sequencer

This block decides when the transceiver core is held in reset and when it sits in low-power mode. An active-low reset pin acts as a hardware reset and also holds the part in low power for as long as it stays low. A pin pulse that is seen low at only one clock edge is treated as a glitch and ignored. When the pin rises again, the block captures the strapped station address and runs a reset sequence of fixed length, then releases the core.

Management software has two controls. A self-clearing reset bit starts the same sequence and reads back as one until the sequence ends. A power-down bit forces low power while it is set. Each entry into low power produces a one-cycle strobe that returns the latching status bits elsewhere in the chip to their defaults. Management register access is never gated by this block. Everything else follows `lowPower` and `coreRst`.

All inputs are synchronous to `clk`. `porN` is the power-on reset of the block's own flops. After `porN` is released, the block waits in the pin-hold state until it samples the reset pin high.

Top module: `phy_reset_power`

## Requirements
- R1: While `porN` is low, `coreRst`=1, `lowPower`=1, `latchClr`=0, `swResetBit`=0 and `phyAddr`=0.
- R2: If `rstPinN` is sampled low at two consecutive edges, then from the second of those edges `coreRst`=1 and `lowPower`=1. Both stay asserted for every further edge at which the pin is sampled low.
- R3: A `rstPinN` low pulse sampled at only one edge changes no output.
- R4: At the first edge where `rstPinN` is sampled high in the pin-hold state, `lowPower` falls and `phyAddr` loads `addrPins`. `phyAddr` changes at no other time.
- R5: After entry into the reset sequence, `coreRst` stays 1 for exactly `RST_CYCLES` cycles and then falls.
- R6: A `swResetWr` strobe sampled while the pin is high and the block is not held starts the sequence at the next edge, with `coreRst`=1 and `swResetBit`=1. If the strobe arrives during a sequence, the count restarts. `swResetBit` clears at the edge where `coreRst` falls.
- R7: A `swResetWr` strobe during pin hold is ignored: `swResetBit` stays 0, including through the following sequence.
- R8: When `pwrDownBit` is sampled 1, `lowPower`=1 from the next edge and `coreRst` is unaffected. When it is sampled 0, and the block is not held, `lowPower` returns to 0 at the next edge.
- R9: `latchClr` is 1 for exactly the cycle in which `lowPower` rises, whether the rise comes from the pin or from the power-down bit.
- R10: A pin hold during a reset sequence aborts the sequence into pin hold and clears `swResetBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset of the block's flops, active low, asynchronous |
| rstPinN | input | 1 | Reset pin, active low, synchronous |
| swResetWr | input | 1 | One-cycle strobe: software wrote one to the reset bit |
| pwrDownBit | input | 1 | Level of the power-down control bit |
| addrPins | input | ADDR_W | Strapped station address |
| coreRst | output | 1 | Reset to the datapath, active high |
| lowPower | output | 1 | Low-power gate; only management access stays enabled |
| latchClr | output | 1 | One-cycle clear of latching status bits |
| swResetBit | output | 1 | Read-back of the self-clearing software reset bit |
| phyAddr | output | ADDR_W | Captured station address |

## Verification
Every output is a flop. Most responses therefore appear one edge after the input is sampled: the pin-hold entry on the second low edge, address capture and the `lowPower` fall on the first high edge, the software reset, and the power-down response. The release of `coreRst` comes `RST_CYCLES` edges after the sequence entry edge. The bench counts edges, and each stimulus task queues a full expected output snapshot tagged with the exact edge number where it is due. A monitor compares these snapshots half a period after that edge. Glitch pulses, aborted sequences and ignored writes are checked both at the due edge and at the edges just after it.

// File: rtl/phy_reset_power_pkg.sv
package phy_reset_power_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_SEQ  = 2'd1,
    ST_RUN  = 2'd2
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAddr;
    logic seqLoad;
    logic seqRun;
    logic holdNext;
  } ctrlStrobes_t;

endpackage

// File: rtl/phy_reset_power_ctrl.sv
module phy_reset_power_ctrl
  import phy_reset_power_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  logic         rstPinN,
  input  logic         swResetWr,
  input  logic         seqDone,
  output ctrlStrobes_t strobes,
  output logic         coreRst,
  output logic         swResetBit
);

  pwrState_t stateQ, stateD;
  logic      pinLowQ;
  logic      swBitD;
  logic      holdCond;

  // pin counts as held on its second consecutive low sample
  assign holdCond = !rstPinN && (pinLowQ || stateQ == ST_HOLD);

  always_comb begin
    stateD              = stateQ;
    swBitD              = swResetBit;
    strobes.captureAddr = 1'b0;
    strobes.seqLoad     = 1'b0;
    strobes.seqRun      = (stateQ == ST_SEQ);
    strobes.holdNext    = holdCond;
    if (holdCond) begin
      stateD = ST_HOLD;
      swBitD = 1'b0;
    end else begin
      case (stateQ)
        ST_HOLD: begin
          stateD              = ST_SEQ;
          strobes.captureAddr = 1'b1;
          strobes.seqLoad     = 1'b1;
        end
        ST_RUN: begin
          if (swResetWr) begin
            stateD          = ST_SEQ;
            strobes.seqLoad = 1'b1;
            swBitD          = 1'b1;
          end
        end
        ST_SEQ: begin
          if (swResetWr) begin
            strobes.seqLoad = 1'b1;
            swBitD          = 1'b1;
          end else if (seqDone) begin
            stateD = ST_RUN;
            swBitD = 1'b0;
          end
        end
        default: stateD = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      stateQ     <= ST_HOLD;
      pinLowQ    <= 1'b0;
      swResetBit <= 1'b0;
    end else begin
      stateQ     <= stateD;
      pinLowQ    <= !rstPinN;
      swResetBit <= swBitD;
    end
  end

  assign coreRst = (stateQ != ST_RUN);

endmodule

// File: rtl/phy_reset_power_dp.sv
module phy_reset_power_dp
  import phy_reset_power_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  ctrlStrobes_t      strobes,
  input  logic              pwrDownBit,
  input  logic [ADDR_W-1:0] addrPins,
  output logic [ADDR_W-1:0] phyAddr,
  output logic              lowPower,
  output logic              latchClr,
  output logic              seqDone
);

  localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] seqCnt;
  logic             lowNext;

  assign lowNext = strobes.holdNext | pwrDownBit;
  assign seqDone = strobes.seqRun && (seqCnt == LAST);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      seqCnt   <= '0;
      phyAddr  <= '0;
      lowPower <= 1'b1;
      latchClr <= 1'b0;
    end else begin
      if (strobes.seqLoad)
        seqCnt <= '0;
      else if (strobes.seqRun && !seqDone)
        seqCnt <= seqCnt + 1'b1;
      if (strobes.captureAddr)
        phyAddr <= addrPins;
      lowPower <= lowNext;
      latchClr <= lowNext & ~lowPower;
    end
  end

endmodule

// File: rtl/phy_reset_power.sv
module phy_reset_power
  import phy_reset_power_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstPinN,
  input  logic              swResetWr,
  input  logic              pwrDownBit,
  input  logic [ADDR_W-1:0] addrPins,
  output logic              coreRst,
  output logic              lowPower,
  output logic              latchClr,
  output logic              swResetBit,
  output logic [ADDR_W-1:0] phyAddr
);

  ctrlStrobes_t strobes;
  logic         seqDone;

  phy_reset_power_ctrl u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .rstPinN    (rstPinN),
    .swResetWr  (swResetWr),
    .seqDone    (seqDone),
    .strobes    (strobes),
    .coreRst    (coreRst),
    .swResetBit (swResetBit)
  );

  phy_reset_power_dp #(
    .ADDR_W     (ADDR_W),
    .RST_CYCLES (RST_CYCLES)
  ) u_dp (
    .clk        (clk),
    .porN       (porN),
    .strobes    (strobes),
    .pwrDownBit (pwrDownBit),
    .addrPins   (addrPins),
    .phyAddr    (phyAddr),
    .lowPower   (lowPower),
    .latchClr   (latchClr),
    .seqDone    (seqDone)
  );

endmodule

// File: rtl/phy_reset_power_checker.sv
module phy_reset_power_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              porN,
  input logic              rstPinN,
  input logic              swResetWr,
  input logic              pwrDownBit,
  input logic              coreRst,
  input logic              lowPower,
  input logic              latchClr,
  input logic              swResetBit,
  input logic [ADDR_W-1:0] phyAddr
);

  logic armedQ;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) armedQ <= 1'b0;
    else       armedQ <= 1'b1;
  end

  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (!porN)
    (armedQ && !rstPinN && !$past(rstPinN)) |=> (coreRst && lowPower));

  assert_glitch_free_R3: assert property (@(posedge clk) disable iff (!porN)
    (!coreRst && rstPinN && !swResetWr) |=> !coreRst);

  assert_addr_capture_R4: assert property (@(posedge clk) disable iff (!porN)
    (phyAddr != $past(phyAddr)) |-> ($past(coreRst) && $past(lowPower) && $past(rstPinN)));

  assert_sw_start_R6: assert property (@(posedge clk) disable iff (!porN)
    (swResetWr && !coreRst && rstPinN) |=> (coreRst && swResetBit));

  assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!porN)
    $fell(swResetBit) |-> (!coreRst || lowPower));

  assert_pd_enter_R8: assert property (@(posedge clk) disable iff (!porN)
    pwrDownBit |=> lowPower);

  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!porN)
    latchClr |-> (lowPower && !$past(lowPower)));

  assert_clr_on_rise_R9: assert property (@(posedge clk) disable iff (!porN)
    $rose(lowPower) |-> latchClr);

endmodule

bind phy_reset_power phy_reset_power_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .porN       (porN),
  .rstPinN    (rstPinN),
  .swResetWr  (swResetWr),
  .pwrDownBit (pwrDownBit),
  .coreRst    (coreRst),
  .lowPower   (lowPower),
  .latchClr   (latchClr),
  .swResetBit (swResetBit),
  .phyAddr    (phyAddr)
);

// File: tb/phy_reset_power_bench.sv
module phy_reset_power_bench;

  localparam int AW = 5;
  localparam int RC = 10;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          rstPinN = 1'b1;
  logic          swResetWr = 1'b0;
  logic          pwrDownBit = 1'b0;
  logic [AW-1:0] addrPins = 5'h15;
  logic          coreRst, lowPower, latchClr, swResetBit;
  logic [AW-1:0] phyAddr;

  phy_reset_power #(.ADDR_W(AW), .RST_CYCLES(RC)) u_phy_reset_power (
    .clk(clk), .porN(porN), .rstPinN(rstPinN), .swResetWr(swResetWr),
    .pwrDownBit(pwrDownBit), .addrPins(addrPins), .coreRst(coreRst),
    .lowPower(lowPower), .latchClr(latchClr), .swResetBit(swResetBit),
    .phyAddr(phyAddr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            at;
    string         rq;
    logic          cr, lp, lc, sb;
    logic [AW-1:0] ad;
  } expItem_t;

  expItem_t sbq[$];

  task automatic expect_at(input int at, input string rq, input logic cr, input logic lp,
                           input logic lc, input logic sb, input logic [AW-1:0] ad);
    expItem_t e;
    e.at = at; e.rq = rq; e.cr = cr; e.lp = lp; e.lc = lc; e.sb = sb; e.ad = ad;
    sbq.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare due snapshots half a period after each edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      expItem_t e;
      e = sbq.pop_front();
      checks++;
      if (e.at != cyc || coreRst !== e.cr || lowPower !== e.lp || latchClr !== e.lc ||
          swResetBit !== e.sb || phyAddr !== e.ad) begin
        errors++;
        $display("FAIL %s at edge %0d (due %0d): actual cr=%b lp=%b lc=%b sb=%b ad=%h expected cr=%b lp=%b lc=%b sb=%b ad=%h",
                 e.rq, cyc, e.at, coreRst, lowPower, latchClr, swResetBit, phyAddr,
                 e.cr, e.lp, e.lc, e.sb, e.ad);
      end
    end
  end

  initial begin
    fork
      begin : stim
        int t;
        // R1: state under power-on reset
        step(2);
        expect_at(cyc + 1, "R1", 1, 1, 0, 0, 5'h00);
        step(1);
        // release: pin high, address captured, sequence runs (R4, R5)
        porN = 1'b1;
        t = cyc;
        expect_at(t + 1, "R4", 1, 0, 0, 0, 5'h15);
        expect_at(t + RC, "R5", 1, 0, 0, 0, 5'h15);
        expect_at(t + RC + 1, "R5", 0, 0, 0, 0, 5'h15);
        step(1);
        addrPins = 5'h0A;   // R4: no effect outside capture
        step(RC + 1);

        // R3: one-edge glitch on the pin
        t = cyc;
        rstPinN = 1'b0;
        expect_at(t + 1, "R3", 0, 0, 0, 0, 5'h15);
        expect_at(t + 2, "R3", 0, 0, 0, 0, 5'h15);
        expect_at(t + 3, "R3", 0, 0, 0, 0, 5'h15);
        step(1);
        rstPinN = 1'b1;
        step(3);

        // R2, R9, R4: held pin, clear strobe, capture at release
        t = cyc;
        rstPinN = 1'b0;
        expect_at(t + 1, "R2", 0, 0, 0, 0, 5'h15);
        expect_at(t + 2, "R2", 1, 1, 1, 0, 5'h15);
        expect_at(t + 3, "R9", 1, 1, 0, 0, 5'h15);
        expect_at(t + 8, "R2", 1, 1, 0, 0, 5'h15);
        expect_at(t + 9, "R4", 1, 0, 0, 0, 5'h07);
        expect_at(t + 8 + RC, "R5", 1, 0, 0, 0, 5'h07);
        expect_at(t + 9 + RC, "R5", 0, 0, 0, 0, 5'h07);
        step(5);
        addrPins = 5'h07;
        step(3);
        rstPinN = 1'b1;
        step(RC + 2);

        // R6: software reset, self-clearing bit, address kept
        t = cyc;
        swResetWr = 1'b1;
        expect_at(t + 1, "R6", 1, 0, 0, 1, 5'h07);
        expect_at(t + RC, "R6", 1, 0, 0, 1, 5'h07);
        expect_at(t + RC + 1, "R6", 0, 0, 0, 0, 5'h07);
        step(1);
        swResetWr = 1'b0;
        step(RC + 1);

        // R6: second write during the sequence restarts the count
        t = cyc;
        swResetWr = 1'b1;
        expect_at(t + 1, "R6", 1, 0, 0, 1, 5'h07);
        expect_at(t + RC + 1, "R6", 1, 0, 0, 1, 5'h07);
        expect_at(t + RC + 3, "R6", 1, 0, 0, 1, 5'h07);
        expect_at(t + RC + 4, "R6", 0, 0, 0, 0, 5'h07);
        step(1);
        swResetWr = 1'b0;
        step(2);
        swResetWr = 1'b1;
        step(1);
        swResetWr = 1'b0;
        step(RC + 1);

        // R8, R9: power-down bit
        t = cyc;
        pwrDownBit = 1'b1;
        expect_at(t + 1, "R8", 0, 1, 1, 0, 5'h07);
        expect_at(t + 2, "R9", 0, 1, 0, 0, 5'h07);
        expect_at(t + 5, "R8", 0, 0, 0, 0, 5'h07);
        step(4);
        pwrDownBit = 1'b0;
        step(2);

        // R7: software write while the pin holds is ignored
        t = cyc;
        rstPinN = 1'b0;
        expect_at(t + 2, "R2", 1, 1, 1, 0, 5'h07);
        expect_at(t + 5, "R7", 1, 1, 0, 0, 5'h07);
        expect_at(t + 7, "R7", 1, 0, 0, 0, 5'h07);
        expect_at(t + 6 + RC, "R7", 1, 0, 0, 0, 5'h07);
        expect_at(t + 7 + RC, "R7", 0, 0, 0, 0, 5'h07);
        step(3);
        swResetWr = 1'b1;
        step(1);
        swResetWr = 1'b0;
        step(2);
        rstPinN = 1'b1;
        step(RC + 2);

        // R10: pin hold aborts a running sequence
        t = cyc;
        swResetWr = 1'b1;
        expect_at(t + 1, "R10", 1, 0, 0, 1, 5'h07);
        expect_at(t + 2, "R10", 1, 0, 0, 1, 5'h07);
        expect_at(t + 3, "R10", 1, 1, 1, 0, 5'h07);
        expect_at(t + 5, "R10", 1, 0, 0, 0, 5'h07);
        expect_at(t + 5 + RC, "R10", 0, 0, 0, 0, 5'h07);
        step(1);
        swResetWr = 1'b0;
        rstPinN = 1'b0;
        step(3);
        rstPinN = 1'b1;
        step(RC + 3);
      end
      begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at edge %0d", cyc);
      end
    join_any
    disable fork;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL %s pending expectation never compared: actual queue=%0d expected 0",
               sbq[0].rq, sbq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule